// File: doc/BRIEF.md
# Module-Identification Memory Two-Wire Slave

This block is a 256-byte two-wire (I2C) slave that holds the identification data of a memory module. A host reads it byte by byte through a seven-bit slave address. The upper four address bits are fixed. The lower three come from board-level select pins, so several modules can share one bus. The host sets an internal word pointer and then reads randomly or sequentially, or writes one or more bytes.

The lower half of the array holds the factory data and can never be changed. The upper half is free for the system to use unless a write-protect pin is held high. After every write transaction the block stays busy for a programmable number of clock cycles, standing in for a nonvolatile program cycle. While busy it does not answer its address. The array is reset to a defined identification image that includes a checksum byte.

SCL and SDA are sampled with the system clock. They pass through synchronizers and a stability filter before any edge or bus condition is decoded. The block drives SDA only as an open-drain pull-down enable.

Top module: `idrom_i2c_slave`

## Requirements
- R1: After reset the array holds these values:
  - byte 0 = 0x80, byte 1 = 0x08, byte 2 = 0x04, byte 3 = 0x0D, byte 4 = 0x0B and byte 5 = 0x01;
  - each byte 6 to 62 holds its own index;
  - byte 63 holds the low 8 bits of the sum of bytes 0 to 62;
  - bytes 64 to 127 hold 0x00, and bytes 128 to 255 hold 0xFF.
- R2: The block acknowledges only the address byte whose upper seven bits are 1010 followed by `addr_sel[2:0]`; bit 0 is the direction, with 1 meaning read. A byte with any other address gets no acknowledge, and the rest of that transaction changes nothing.
- R3: A write of one word-address byte, a repeated START and a read return the byte stored at that address.
- R4: The word pointer advances by one after each byte read or written and wraps from 255 to 0.
- R5: With `wp_i` low, a data byte written to addresses 128 to 255 is stored, and each data byte is acknowledged.
- R6: A data byte aimed at addresses 0 to 127 is acknowledged, but the stored value does not change.
- R7: With `wp_i` high, a data byte aimed at addresses 128 to 255 is acknowledged, but the stored value does not change.
- R8: A STOP that ends a transaction containing at least one data byte starts a busy window of `BUSY_CYCLES` clocks. During this window the block's own address is not acknowledged. After the window the address is acknowledged again. A transaction with no data byte starts no window.
- R9: When the host does not acknowledge a read byte, the block ends the transfer and releases SDA. SDA is also released after reset and whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the board |
| sda_i | input | 1 | Bus data line as seen on the board (wired-AND of all drivers) |
| sda_oe | output | 1 | Pull SDA low when 1; release when 0 |
| addr_sel | input | 3 | Low three bits of the slave address |
| wp_i | input | 1 | Write protect for the upper half, active high |

## Verification
The bench aims at these corner cases:
- **Wrap-around.** A multi-byte write starting at 254 runs through the top of the array and into the locked bottom. A design that mis-wraps the pointer would corrupt bytes 0 and 1. A design that gates protection on the starting address rather than on each byte would corrupt them as well.
- **Busy window.** The address is probed immediately after a write STOP and again just before the window ends. Both probes must be refused, and a probe after the window must be accepted. A block that re-enabled early, or that armed the window on an address-only transaction, would answer at the wrong time.
- **Protection and address filtering.** Writes go to locked and protected bytes, and to a foreign slave address, and each is read back. A block that refused the acknowledge, or that let the data through, would show up as a mismatch.
- **Reset image.** The whole array is read once from reset, so a wrong default or checksum is caught.

// File: rtl/idrom_pkg.sv
package idrom_pkg;

  // Position of the checksum byte; it covers every byte below it.
  localparam int CSUM_IDX = 63;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_DACK,
    S_WADDR,
    S_AACK,
    S_WDATA,
    S_WACK,
    S_RDATA,
    S_RACK
  } xfer_state_t;

  // Identification field below the checksum byte.
  function automatic logic [7:0] id_byte(input int idx);
    case (idx)
      0:       return 8'h80;
      1:       return 8'h08;
      2:       return 8'h04;
      3:       return 8'h0D;
      4:       return 8'h0B;
      5:       return 8'h01;
      default: return 8'(idx);
    endcase
  endfunction

  // Reset image of the whole array.
  function automatic logic [7:0] reset_byte(input int idx, input int locked);
    logic [7:0] acc;
    if (idx < CSUM_IDX) return id_byte(idx);
    if (idx == CSUM_IDX) begin
      acc = '0;
      for (int k = 0; k < CSUM_IDX; k++) acc = acc + id_byte(k);
      return acc;
    end
    if (idx < locked) return 8'h00;
    return 8'hFF;
  endfunction

endpackage

// File: rtl/idrom_line_cond.sv
module idrom_line_cond #(
  parameter int SYNC = 2,
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_w;
  logic [NLINES-1:0] lvl_w;
  logic [NLINES-1:0] prev_q;

  assign raw_w = {sda_raw, scl_raw};

  // Bit 0 is the clock line, bit 1 the data line; both see identical delay.
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [SYNC-1:0] sync_q;
    logic [FILT-1:0] hist_q;
    logic            lvl_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= '1;
        hist_q <= '1;
        lvl_r  <= 1'b1;
      end else begin
        sync_q <= {sync_q[SYNC-2:0], raw_w[g]};
        hist_q <= {hist_q[FILT-2:0], sync_q[SYNC-1]};
        if (&hist_q)       lvl_r <= 1'b1;
        else if (~|hist_q) lvl_r <= 1'b0;
      end
    end

    assign lvl_w[g] = lvl_r;
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= lvl_w;
  end

  assign sda_lvl   = lvl_w[1];
  assign scl_rise  = lvl_w[0] & ~prev_q[0];
  assign scl_fall  = ~lvl_w[0] & prev_q[0];
  assign start_evt = lvl_w[0] & prev_q[0] & prev_q[1] & ~lvl_w[1];
  assign stop_evt  = lvl_w[0] & prev_q[0] & ~prev_q[1] & lvl_w[1];

endmodule

// File: rtl/idrom_busy_timer.sv
module idrom_busy_timer #(
  parameter int CYCLES = 1500000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic busy
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (arm)          cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/idrom_store.sv
module idrom_store
  import idrom_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int AW     = 8,
  parameter int LOCKED = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          wp,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  localparam logic [AW:0] LOCK_BOUND = (AW + 1)'(LOCKED);

  logic [7:0] mem_q [DEPTH];
  logic       commit;

  // Protection is judged per byte, from the address that byte lands on.
  assign commit = wr_req && ({1'b0, waddr} >= LOCK_BOUND) && !wp;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= reset_byte(i, LOCKED);
    end else if (commit) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/idrom_i2c_slave.sv
module idrom_i2c_slave
  import idrom_pkg::*;
#(
  parameter int         DEPTH       = 256,
  parameter int         BUSY_CYCLES = 1500000,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter logic [3:0] DEV_PREFIX  = 4'b1010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] addr_sel,
  input  logic       wp_i
);

  localparam int AW     = $clog2(DEPTH);
  localparam int LOCKED = DEPTH / 2;

  logic          sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic          busy_w;
  xfer_state_t   state_q;
  logic [7:0]    shreg_q;
  logic [3:0]    bitcnt_q;
  logic [AW-1:0] ptr_q;
  logic [6:0]    tx_q;
  logic          rw_q, mack_q, wrote_q;
  logic [7:0]    rdata;
  logic          byte_done, dev_hit, wr_fire;

  idrom_line_cond #(
    .SYNC(SYNC_STAGES),
    .FILT(FILT_LEN)
  ) u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl_raw  (scl_i),
    .sda_raw  (sda_i),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  idrom_busy_timer #(
    .CYCLES(BUSY_CYCLES)
  ) u_busy (
    .clk (clk),
    .rst (rst),
    .arm (stop_evt && wrote_q),
    .busy(busy_w)
  );

  idrom_store #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .LOCKED(LOCKED)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .wr_req(wr_fire),
    .waddr (ptr_q),
    .wdata (shreg_q),
    .wp    (wp_i),
    .raddr (ptr_q),
    .rdata (rdata)
  );

  assign byte_done = scl_fall && (bitcnt_q == 4'd8);
  assign dev_hit   = (shreg_q[7:1] == {DEV_PREFIX, addr_sel}) && !busy_w;
  assign wr_fire   = (state_q == S_WDATA) && byte_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      sda_oe   <= 1'b0;
      shreg_q  <= '0;
      bitcnt_q <= '0;
      ptr_q    <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      wrote_q  <= 1'b0;
    end else if (start_evt) begin
      state_q  <= S_DEV;
      bitcnt_q <= '0;
      sda_oe   <= 1'b0;
    end else if (stop_evt) begin
      state_q  <= S_IDLE;
      sda_oe   <= 1'b0;
      wrote_q  <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: ;
        S_DEV, S_WADDR, S_WDATA: begin
          if (scl_rise) begin
            shreg_q  <= {shreg_q[6:0], sda_lvl};
            bitcnt_q <= bitcnt_q + 1'b1;
          end else if (byte_done) begin
            bitcnt_q <= '0;
            if (state_q == S_DEV) begin
              if (dev_hit) begin
                state_q <= S_DACK;
                sda_oe  <= 1'b1;
                rw_q    <= shreg_q[0];
              end else begin
                state_q <= S_IDLE;
              end
            end else if (state_q == S_WADDR) begin
              ptr_q   <= shreg_q[AW-1:0];
              state_q <= S_AACK;
              sda_oe  <= 1'b1;
            end else begin
              ptr_q   <= ptr_q + 1'b1;
              wrote_q <= 1'b1;
              state_q <= S_WACK;
              sda_oe  <= 1'b1;
            end
          end
        end
        S_DACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              tx_q     <= rdata[6:0];
              sda_oe   <= ~rdata[7];
              bitcnt_q <= 4'd1;
              state_q  <= S_RDATA;
            end else begin
              sda_oe   <= 1'b0;
              bitcnt_q <= '0;
              state_q  <= S_WADDR;
            end
          end
        end
        S_AACK, S_WACK: begin
          if (scl_fall) begin
            sda_oe   <= 1'b0;
            bitcnt_q <= '0;
            state_q  <= S_WDATA;
          end
        end
        S_RDATA: begin
          if (scl_fall) begin
            if (bitcnt_q == 4'd8) begin
              sda_oe  <= 1'b0;
              ptr_q   <= ptr_q + 1'b1;
              state_q <= S_RACK;
            end else begin
              sda_oe   <= ~tx_q[6];
              tx_q     <= {tx_q[5:0], 1'b0};
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_q     <= rdata[6:0];
              sda_oe   <= ~rdata[7];
              bitcnt_q <= 4'd1;
              state_q  <= S_RDATA;
            end else begin
              state_q  <= S_IDLE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/idrom_checker.sv
module idrom_checker
  import idrom_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          sda_oe,
  input logic          wp,
  input logic          busy,
  input xfer_state_t   state,
  input logic [AW-1:0] ptr,
  input logic [7:0]    lo_first,
  input logic [7:0]    lo_last,
  input logic [7:0]    hi_first
);

  // R8: no address acknowledge while the program window runs
  assert_busy_silent_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> (state != S_DACK));

  // R6: the factory half never moves
  assert_lock_lo_R6: assert property (@(posedge clk) disable iff (rst)
    $stable(lo_first) && $stable(lo_last));

  // R7: a protected upper byte holds while the pin is high
  assert_wp_guard_R7: assert property (@(posedge clk) disable iff (rst)
    wp |=> $stable(hi_first));

  // R2: SDA is pulled only in acknowledge or read-data slots
  assert_drive_window_R2: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (state == S_DACK || state == S_AACK ||
                state == S_WACK || state == S_RDATA));

  // R4: a finished read byte moves the pointer on by one, with wrap
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_RACK && $past(state) == S_RDATA) |-> (ptr == $past(ptr) + 1'b1));

  // R9: an idle slave leaves SDA alone
  assert_idle_release_R9: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !sda_oe);

endmodule

bind idrom_i2c_slave idrom_checker #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sda_oe  (sda_oe),
  .wp      (wp_i),
  .busy    (busy_w),
  .state   (state_q),
  .ptr     (ptr_q),
  .lo_first(u_store.mem_q[0]),
  .lo_last (u_store.mem_q[LOCKED-1]),
  .hi_first(u_store.mem_q[LOCKED])
);

// File: tb/sim_idrom_i2c_slave.sv
module sim_idrom_i2c_slave;

  localparam int BUSY = 2000;
  localparam int Q    = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [2:0] sel = 3'd0;
  logic       wp_b = 1'b0;
  logic       sda_line;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [256];

  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  idrom_i2c_slave #(.BUSY_CYCLES(BUSY)) u0 (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl_m),
    .sda_i   (sda_line),
    .sda_oe  (sda_oe),
    .addr_sel(sel),
    .wp_i    (wp_b)
  );

  // Expected reset image, from R1
  function automatic logic [7:0] dflt(input int i);
    logic [7:0] s;
    case (i)
      0: return 8'h80;
      1: return 8'h08;
      2: return 8'h04;
      3: return 8'h0D;
      4: return 8'h0B;
      5: return 8'h01;
      default: ;
    endcase
    if (i < 63) return i[7:0];
    if (i == 63) begin
      s = 8'h00;
      for (int k = 0; k < 63; k++) s = s + dflt(k);
      return s;
    end
    if (i < 128) return 8'h00;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] dev_byte(input logic [2:0] s, input logic rd);
    return {4'b1010, s, rd};
  endfunction

  task automatic chk8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic probe(input logic [7:0] dv, output logic ack);
    bus_start;
    send_byte(dv, ack);
    bus_stop;
  endtask

  // Random/sequential read from address a, n bytes, checked against the model
  task automatic rd_seq(input logic [7:0] a, input int n, input string tag);
    logic       ack;
    logic [7:0] v;
    bus_start;
    send_byte(dev_byte(sel, 1'b0), ack);
    chk1({tag, " write-address ack"}, ack, 1'b1);
    send_byte(a, ack);
    chk1({tag, " word ack"}, ack, 1'b1);
    bus_start;
    send_byte(dev_byte(sel, 1'b1), ack);
    chk1({tag, " read-address ack"}, ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, v);
      chk8($sformatf("%s byte %0d", tag, (int'(a) + i) % 256), v, model[(int'(a) + i) % 256]);
    end
    bus_stop;
  endtask

  // Write n (<=4) data bytes from address a; model follows R5/R6/R7
  task automatic wr_seq(input logic [7:0] a, input int n, input logic [7:0] d [4],
                        input string tag);
    logic ack;
    int   idx;
    bus_start;
    send_byte(dev_byte(sel, 1'b0), ack);
    chk1({tag, " address ack"}, ack, 1'b1);
    send_byte(a, ack);
    chk1({tag, " word ack"}, ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ack);
      chk1({tag, " data ack"}, ack, 1'b1);
      idx = (int'(a) + i) % 256;
      if (idx >= 128 && !wp_b) model[idx] = d[i];
    end
    bus_stop;
  endtask

  task automatic wait_prog;
    tick(BUSY + 50);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic       ack;
    logic [7:0] d [4];
    logic [7:0] a;
    logic [7:0] v;
    logic [2:0] other;

    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) model[i] = dflt(i);
    sel = 3'($urandom % 8);

    tick(5);
    rst = 1'b0;
    tick(5);
    chk1("R9 reset release", sda_oe, 1'b0);

    // R1 whole image, plus one byte past the top for the R4 wrap
    rd_seq(8'd0, 256, "R1");
    bus_start;
    send_byte(dev_byte(sel, 1'b1), ack);
    recv_byte(1'b0, v);
    bus_stop;
    chk8("R4 wrap after 255", v, model[0]);

    // R2 foreign addresses get no ack
    for (int i = 0; i < 4; i++) begin
      other = sel ^ 3'(1 + ($urandom % 7));
      probe(dev_byte(other, 1'($urandom % 2)), ack);
      chk1("R2 other select", ack, 1'b0);
    end
    probe({4'b0110, sel, 1'b0}, ack);
    chk1("R2 other prefix", ack, 1'b0);
    // R2 data sent after a refused address changes nothing and arms no window
    bus_start;
    send_byte(dev_byte(sel ^ 3'd4, 1'b0), ack);
    chk1("R2 refused write", ack, 1'b0);
    send_byte(8'hA0, ack);
    send_byte(8'h5A, ack);
    bus_stop;
    probe(dev_byte(sel, 1'b0), ack);
    chk1("R2 no window after refused write", ack, 1'b1);
    rd_seq(8'hA0, 1, "R2 unchanged");

    // R5 random single-byte writes in the open half
    for (int i = 0; i < 5; i++) begin
      a = 8'(128 + ($urandom % 128));
      d[0] = 8'($urandom);
      wr_seq(a, 1, d, "R5");
      wait_prog;
      rd_seq(a, 1, "R5 readback");
    end

    // R4/R5/R6 burst across the top into the locked half
    d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'h44;
    wr_seq(8'd254, 4, d, "R6 wrap burst");
    wait_prog;
    rd_seq(8'd254, 4, "R4 wrap burst readback");

    // R6 locked half
    for (int i = 0; i < 3; i++) begin
      a = 8'($urandom % 128);
      d[0] = 8'($urandom);
      wr_seq(a, 1, d, "R6");
      wait_prog;
      rd_seq(a, 1, "R6 readback");
    end

    // R7 protect pin
    wp_b = 1'b1;
    for (int i = 0; i < 3; i++) begin
      a = 8'(128 + ($urandom % 128));
      d[0] = ~model[a];
      wr_seq(a, 1, d, "R7");
      wait_prog;
      rd_seq(a, 1, "R7 readback");
    end
    wp_b = 1'b0;

    // R8 program window
    d[0] = 8'hC3;
    wr_seq(8'd200, 1, d, "R8 write");
    probe(dev_byte(sel, 1'b0), ack);
    chk1("R8 right after stop", ack, 1'b0);
    tick(1200);
    probe(dev_byte(sel, 1'b1), ack);
    chk1("R8 late in window", ack, 1'b0);
    tick(600);
    probe(dev_byte(sel, 1'b0), ack);
    chk1("R8 after window", ack, 1'b1);
    rd_seq(8'd200, 1, "R8 readback");

    // R3 random reads
    for (int i = 0; i < 8; i++) begin
      a = 8'($urandom);
      rd_seq(a, 1 + ($urandom % 3), "R3");
    end

    // R9 host NACK ends the read and frees the line
    bus_start;
    send_byte(dev_byte(sel, 1'b1), ack);
    recv_byte(1'b0, v);
    tick(2);
    chk1("R9 released after host nack", sda_oe, 1'b0);
    bus_stop;
    chk1("R9 released after stop", sda_oe, 1'b0);
    probe(dev_byte(sel, 1'b0), ack);
    chk1("R9 next transaction", ack, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule